// File: doc/BRIEF.md
# Flash Sector Decoder with Selectable Bank Layout

This block maps a byte address inside an on-chip flash window to the sector that holds it. The result is a descriptor with five fields: which bank the sector sits in, the sector's position inside that bank, a combined sector number, the first address of the sector and its size in bytes. An erase or protection controller upstream uses the descriptor to choose the sector to operate on and to check the span it covers.

Sectors are not all the same size. Each bank opens with four small sectors, followed by one medium sector. Every sector after that is large. A mode input picks one of two layouts. The first is a single bank that spans the whole window. The second splits the window into two equal banks, and the upper bank repeats the sector shape of the lower one. An address that falls outside the window raises an error flag instead of producing a descriptor.

The block takes one address per clock. The answer appears one clock after the strobe, marked by a single-cycle valid pulse. With the default parameters the window is 1 MiB at 0x0800_0000, the small sectors are 16 KiB, the medium sector is 64 KiB and the large sectors are 128 KiB.

Top module: `flash_sector_decoder`

## Requirements
- R1: While `rst` is high at a clock edge, every output is zero after that edge.
- R2: `out_valid` is high in the cycle after each cycle in which `in_valid` is high, and it is low in every other cycle. The outputs answer the address and mode of that strobe.
- R3: An address below 0x0800_0000, or at or above 0x0800_0000 plus the flash size, sets `out_range_err` to 1. In that case `out_bank`, `out_index`, `out_secnum`, `out_start` and `out_size` are all zero. An address inside the window clears `out_range_err`.
- R4: In every bank, sectors 0 to 3 are 16 KiB each and start at bank offsets 0x0000, 0x4000, 0x8000 and 0xC000.
- R5: Sector 4 of every bank starts at bank offset 0x1_0000 and is 64 KiB.
- R6: Every sector from index 5 on is 128 KiB and starts at bank offset 0x2_0000 + (index−5)×0x2_0000. In single-bank layout the sectors run from 0 to 11, and sector 11 starts at 0x080E_0000. Every reported start is aligned to the reported size.
- R7: With `dual_mode`=1, an address at or above the window base plus half the flash size (0x0808_0000 by default) gives `out_bank`=1. Indices restart at 0 at that point, so each bank holds sectors 0 to 7.
- R8: `out_secnum` equals `out_bank` shifted left by 4, plus `out_index`. Upper-bank sector 3 therefore reads 0x13, and a lower-bank sector reads as its index alone.
- R9: With `dual_mode`=0, `out_bank` is 0 for every address. An address in the upper half decodes as a single-bank sector; for example, 0x0808_0000 gives index 8.
- R10: In a cycle without a strobe, the descriptor fields and `out_range_err` keep the values they had before that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Strobe: decode `in_addr` in this cycle |
| in_addr | input | ADDR_W (32) | Byte address to decode |
| dual_mode | input | 1 | 0: one contiguous bank; 1: two half-size banks |
| out_valid | output | 1 | One-cycle pulse: the descriptor has been updated |
| out_range_err | output | 1 | The address was outside the flash window |
| out_bank | output | 1 | Bank holding the sector (0 lower, 1 upper) |
| out_index | output | 4 | Sector index within its bank |
| out_secnum | output | 8 | Bank in bits 7:4, index in bits 3:0 |
| out_start | output | ADDR_W (32) | First byte address of the sector |
| out_size | output | ADDR_W (32) | Sector size in bytes |

## Verification
The assertions assume that `dual_mode` is steady in any cycle where `in_valid` is high. They also assume that `rst` is applied before the first strobe, so no register is sampled while it still holds an unknown value. The bench changes the mode only at negative clock edges, together with the address. It holds `rst` high from time zero for several cycles, and it asserts `in_valid` only after reset is released. Its addresses include the exact first and last byte of the sector boundaries and of the window edges, along with a pseudo-random sweep that reaches just past both ends of the window.

// File: rtl/flash_sector_pkg.sv
package flash_sector_pkg;
   // Field widths fixed by the sector-number encoding: bank above, index below.
   localparam int unsigned IDX_W    = 4;
   localparam int unsigned SECNUM_W = 8;
   localparam int unsigned ADDR_W   = 32;

   typedef struct packed {
      logic                bank;
      logic [IDX_W-1:0]    index;
      logic [SECNUM_W-1:0] secnum;
      logic [ADDR_W-1:0]   start;
      logic [ADDR_W-1:0]   size;
   } sector_desc_t;
endpackage

// File: rtl/fsd_window_check.sv
// Decides whether an address lies in the flash window; yields its offset.
module fsd_window_check #(
   parameter int unsigned ADDR_W      = 32,
   parameter int unsigned OFF_W       = 20,
   parameter int unsigned BASE_ADDR   = 32'h0800_0000,
   parameter int unsigned FLASH_BYTES = 32'h0010_0000
) (
   input  logic [ADDR_W-1:0] addr,
   output logic              in_win,
   output logic [OFF_W-1:0]  off
);
   localparam logic [ADDR_W:0] WIN_LO = (ADDR_W+1)'(BASE_ADDR);
   localparam logic [ADDR_W:0] WIN_HI = (ADDR_W+1)'(BASE_ADDR) + (ADDR_W+1)'(FLASH_BYTES);

   logic [ADDR_W:0]   addr_ext;
   logic [ADDR_W-1:0] rel;

   always_comb begin
      addr_ext = {1'b0, addr};
      in_win   = (addr_ext >= WIN_LO) && (addr_ext < WIN_HI);
      rel      = addr - ADDR_W'(BASE_ADDR);
      off      = OFF_W'(rel);
   end
endmodule

// File: rtl/fsd_bank_split.sv
// Chooses the bank from the window offset and rebases the offset into it.
module fsd_bank_split #(
   parameter int unsigned OFF_W       = 20,
   parameter int unsigned FLASH_BYTES = 32'h0010_0000
) (
   input  logic [OFF_W-1:0] off,
   input  logic             dual,
   output logic             bank,
   output logic [OFF_W-1:0] bank_off
);
   localparam logic [OFF_W-1:0] HALF_OFF = OFF_W'(FLASH_BYTES / 2);

   always_comb begin
      if (dual && (off >= HALF_OFF)) begin
         bank     = 1'b1;
         bank_off = off - HALF_OFF;
      end else begin
         bank     = 1'b0;
         bank_off = off;
      end
   end
endmodule

// File: rtl/fsd_sector_locate.sv
// Finds the sector index, start offset and size within one bank.
module fsd_sector_locate #(
   parameter int unsigned OFF_W       = 20,
   parameter int unsigned IDX_W       = 4,
   parameter int unsigned ADDR_W      = 32,
   parameter int unsigned SMALL_BYTES = 32'h0000_4000,
   parameter int unsigned SMALL_COUNT = 4,
   parameter int unsigned MID_BYTES   = 32'h0001_0000,
   parameter int unsigned LARGE_BYTES = 32'h0002_0000
) (
   input  logic [OFF_W-1:0]  bank_off,
   output logic [IDX_W-1:0]  idx,
   output logic [OFF_W-1:0]  start_off,
   output logic [ADDR_W-1:0] size
);
   localparam int unsigned SMALL_LG  = $clog2(SMALL_BYTES);
   localparam int unsigned LARGE_LG  = $clog2(LARGE_BYTES);
   localparam int unsigned SMALL_END = SMALL_COUNT * SMALL_BYTES;
   localparam int unsigned MID_END   = SMALL_END + MID_BYTES;

   logic [OFF_W-1:0] slot;
   logic [OFF_W-1:0] rel;

   always_comb begin
      slot      = '0;
      rel       = '0;
      if (bank_off < OFF_W'(SMALL_END)) begin
         slot      = bank_off >> SMALL_LG;
         idx       = IDX_W'(slot);
         start_off = slot << SMALL_LG;
         size      = ADDR_W'(SMALL_BYTES);
      end else if (bank_off < OFF_W'(MID_END)) begin
         idx       = IDX_W'(SMALL_COUNT);
         start_off = OFF_W'(SMALL_END);
         size      = ADDR_W'(MID_BYTES);
      end else begin
         rel       = bank_off - OFF_W'(MID_END);
         slot      = rel >> LARGE_LG;
         idx       = IDX_W'(SMALL_COUNT + 1) + IDX_W'(slot);
         start_off = OFF_W'(MID_END) + (slot << LARGE_LG);
         size      = ADDR_W'(LARGE_BYTES);
      end
   end
endmodule

// File: rtl/flash_sector_decoder.sv
module flash_sector_decoder
   import flash_sector_pkg::*;
#(
   parameter int unsigned BASE_ADDR   = 32'h0800_0000,
   parameter int unsigned FLASH_BYTES = 32'h0010_0000,
   parameter int unsigned SMALL_BYTES = 32'h0000_4000,
   parameter int unsigned SMALL_COUNT = 4,
   parameter int unsigned MID_BYTES   = 32'h0001_0000,
   parameter int unsigned LARGE_BYTES = 32'h0002_0000
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                in_valid,
   input  logic [ADDR_W-1:0]   in_addr,
   input  logic                dual_mode,
   output logic                out_valid,
   output logic                out_range_err,
   output logic                out_bank,
   output logic [IDX_W-1:0]    out_index,
   output logic [SECNUM_W-1:0] out_secnum,
   output logic [ADDR_W-1:0]   out_start,
   output logic [ADDR_W-1:0]   out_size
);
   localparam int unsigned OFF_W      = $clog2(FLASH_BYTES);
   localparam int unsigned HALF_BYTES = FLASH_BYTES / 2;
   localparam int unsigned MID_END    = SMALL_COUNT * SMALL_BYTES + MID_BYTES;
   localparam int unsigned MAX_IDX    = SMALL_COUNT + (FLASH_BYTES - MID_END) / LARGE_BYTES;

   // Elaboration-time parameter checks
   if ((FLASH_BYTES & (FLASH_BYTES - 1)) != 0) begin : g_chk_flash
      $error("flash size must be a power of two");
   end
   if ((SMALL_BYTES & (SMALL_BYTES - 1)) != 0) begin : g_chk_small
      $error("small sector size must be a power of two");
   end
   if ((LARGE_BYTES & (LARGE_BYTES - 1)) != 0) begin : g_chk_large
      $error("large sector size must be a power of two");
   end
   if (MID_END > HALF_BYTES) begin : g_chk_half
      $error("small and medium sectors must fit in half the flash");
   end
   if (((HALF_BYTES - MID_END) % LARGE_BYTES) != 0) begin : g_chk_tile
      $error("large sectors must tile each half exactly");
   end
   if (MAX_IDX >= (1 << IDX_W)) begin : g_chk_idx
      $error("sector index does not fit its field");
   end

   logic             in_win;
   logic [OFF_W-1:0] win_off;
   logic             bank_c;
   logic [OFF_W-1:0] bank_off;
   logic [IDX_W-1:0] idx_c;
   logic [OFF_W-1:0] start_off;
   logic [ADDR_W-1:0] size_c;
   sector_desc_t     desc_c;
   sector_desc_t     desc_q;
   logic             err_q;
   logic             vld_q;

   fsd_window_check #(
      .ADDR_W(ADDR_W), .OFF_W(OFF_W),
      .BASE_ADDR(BASE_ADDR), .FLASH_BYTES(FLASH_BYTES)
   ) u_window (
      .addr(in_addr), .in_win(in_win), .off(win_off)
   );

   fsd_bank_split #(
      .OFF_W(OFF_W), .FLASH_BYTES(FLASH_BYTES)
   ) u_bank (
      .off(win_off), .dual(dual_mode), .bank(bank_c), .bank_off(bank_off)
   );

   fsd_sector_locate #(
      .OFF_W(OFF_W), .IDX_W(IDX_W), .ADDR_W(ADDR_W),
      .SMALL_BYTES(SMALL_BYTES), .SMALL_COUNT(SMALL_COUNT),
      .MID_BYTES(MID_BYTES), .LARGE_BYTES(LARGE_BYTES)
   ) u_locate (
      .bank_off(bank_off), .idx(idx_c), .start_off(start_off), .size(size_c)
   );

   always_comb begin
      desc_c.bank   = bank_c;
      desc_c.index  = idx_c;
      desc_c.secnum = SECNUM_W'({bank_c, idx_c});
      desc_c.start  = ADDR_W'(BASE_ADDR)
                    + (bank_c ? ADDR_W'(HALF_BYTES) : '0)
                    + ADDR_W'(start_off);
      desc_c.size   = size_c;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         vld_q  <= 1'b0;
         err_q  <= 1'b0;
         desc_q <= '0;
      end else begin
         vld_q <= in_valid;
         if (in_valid) begin
            err_q  <= !in_win;
            desc_q <= in_win ? desc_c : '0;
         end
      end
   end

   assign out_valid     = vld_q;
   assign out_range_err = err_q;
   assign out_bank      = desc_q.bank;
   assign out_index     = desc_q.index;
   assign out_secnum    = desc_q.secnum;
   assign out_start     = desc_q.start;
   assign out_size      = desc_q.size;

   // Assertions
   p_pulse_follows_r2: assert property (@(posedge clk) disable iff (rst)
      in_valid |=> out_valid);
   p_pulse_only_r2: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> !out_valid);
   p_below_base_r3: assert property (@(posedge clk) disable iff (rst)
      (in_valid && ({1'b0, in_addr} < (ADDR_W+1)'(BASE_ADDR)))
      |=> (out_range_err && out_start == '0 && out_size == '0 && out_secnum == '0));
   p_aligned_size_r6: assert property (@(posedge clk) disable iff (rst)
      (out_valid && !out_range_err)
      |-> (((out_size == ADDR_W'(SMALL_BYTES)) || (out_size == ADDR_W'(MID_BYTES))
            || (out_size == ADDR_W'(LARGE_BYTES)))
           && (((out_start - ADDR_W'(BASE_ADDR)) & (out_size - 1'b1)) == '0)));
   p_upper_bank_r7: assert property (@(posedge clk) disable iff (rst)
      (in_valid && dual_mode && in_win && (win_off >= OFF_W'(HALF_BYTES)))
      |=> (out_bank && !out_range_err));
   p_single_bank_r9: assert property (@(posedge clk) disable iff (rst)
      (in_valid && !dual_mode) |=> !out_bank);
   p_hold_r10: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> ($stable(out_start) && $stable(out_size)
                     && $stable(out_secnum) && $stable(out_range_err)));
endmodule

// File: tb/flash_sector_decoder_tb.sv
`timescale 1ns/1ps
module flash_sector_decoder_tb;
   localparam int unsigned BASE  = 32'h0800_0000;
   localparam int unsigned FSIZE = 32'h0010_0000;

   typedef struct packed {
      logic        err;
      logic        bank;
      logic [3:0]  index;
      logic [7:0]  secnum;
      logic [31:0] start;
      logic [31:0] size;
   } exp_t;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        in_valid = 1'b0;
   logic [31:0] in_addr = '0;
   logic        dual_mode = 1'b0;
   logic        out_valid, out_range_err, out_bank;
   logic [3:0]  out_index;
   logic [7:0]  out_secnum;
   logic [31:0] out_start, out_size;

   int checks = 0;
   int fails  = 0;
   int pushed = 0;
   int seen   = 0;
   exp_t   q[$];
   string  tags[$];
   exp_t   last_exp;
   logic   done = 1'b0;

   always #2.5 clk = ~clk;

   flash_sector_decoder u_dut (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_addr(in_addr),
      .dual_mode(dual_mode), .out_valid(out_valid), .out_range_err(out_range_err),
      .out_bank(out_bank), .out_index(out_index), .out_secnum(out_secnum),
      .out_start(out_start), .out_size(out_size)
   );

   // Reference model: walks the sector list of each bank.
   function automatic exp_t model(input logic [31:0] a, input logic dual);
      exp_t e;
      longint unsigned st, sz, bank_base, bank_end;
      e = '0;
      if (a < BASE || {32'h0, a} >= longint'(BASE) + longint'(FSIZE)) begin
         e.err = 1'b1;
         return e;
      end
      for (int b = 0; b < (dual ? 2 : 1); b++) begin
         bank_base = longint'(BASE) + (dual ? longint'(b) * (FSIZE / 2) : 0);
         bank_end  = bank_base + (dual ? FSIZE / 2 : FSIZE);
         st = bank_base;
         for (int i = 0; i < 16; i++) begin
            sz = (i < 4) ? 32'h4000 : (i == 4) ? 32'h1_0000 : 32'h2_0000;
            if (st >= bank_end) break;
            if (a >= st && a < st + sz) begin
               e.bank   = b[0];
               e.index  = i[3:0];
               e.secnum = {3'b000, b[0], i[3:0]};
               e.start  = st[31:0];
               e.size   = sz[31:0];
            end
            st = st + sz;
         end
      end
      return e;
   endfunction

   function automatic exp_t actual();
      exp_t r;
      r = {out_range_err, out_bank, out_index, out_secnum, out_start, out_size};
      return r;
   endfunction

   task automatic check(input string tag, input exp_t act, input exp_t exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   // Driver: one strobe per call, inputs change at the falling edge.
   task automatic drive(input logic [31:0] a, input logic dual, input string tag);
      exp_t e;
      e = model(a, dual);
      in_valid  = 1'b1;
      in_addr   = a;
      dual_mode = dual;
      q.push_back(e);
      tags.push_back(tag);
      last_exp = e;
      pushed++;
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   // Monitor: compares each result against the queued expectation.
   initial begin
      forever begin
         @(negedge clk);
         if (!rst && out_valid) begin
            seen++;
            if (q.size() == 0) begin
               checks++;
               fails++;
               $display("FAIL R2 act=unexpected pulse exp=no pulse");
            end else begin
               check(tags.pop_front(), actual(), q.pop_front());
            end
         end
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog act=running exp=finished");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      logic [31:0] lfsr;
      repeat (4) @(negedge clk);
      check("R1", {out_valid, actual()}, '0);
      rst = 1'b0;
      @(negedge clk);

      // R4 / R5 / R6 / R9: single-bank layout
      drive(32'h0800_0000, 1'b0, "R4");
      drive(32'h0800_3FFF, 1'b0, "R4");
      drive(32'h0800_C000, 1'b0, "R4");
      drive(32'h0800_FFFF, 1'b0, "R4");
      drive(32'h0801_0000, 1'b0, "R5");
      drive(32'h0801_FFFF, 1'b0, "R5");
      drive(32'h0802_0000, 1'b0, "R6");
      drive(32'h0803_FFFF, 1'b0, "R6");
      drive(32'h080E_0000, 1'b0, "R6");
      drive(32'h080F_FFFF, 1'b0, "R6");
      drive(32'h0808_0000, 1'b0, "R9");
      // R7 / R8: dual-bank layout
      drive(32'h0800_0000, 1'b1, "R7");
      drive(32'h0806_0000, 1'b1, "R7");
      drive(32'h0807_FFFF, 1'b1, "R7");
      drive(32'h0808_0000, 1'b1, "R7");
      drive(32'h0808_C000, 1'b1, "R8");
      drive(32'h0809_0000, 1'b1, "R8");
      drive(32'h080A_0000, 1'b1, "R8");
      drive(32'h080F_FFFF, 1'b1, "R8");
      // R3: window edges
      drive(32'h07FF_FFFF, 1'b0, "R3");
      drive(32'h0810_0000, 1'b0, "R3");
      drive(32'h0810_0000, 1'b1, "R3");
      drive(32'h0000_0000, 1'b1, "R3");
      drive(32'hFFFF_FFFF, 1'b0, "R3");
      drive(32'h0800_4000, 1'b0, "R3");
      // R10: descriptor holds across idle cycles
      drive(32'h0809_4000, 1'b1, "R10");
      repeat (3) @(negedge clk);
      check("R10", actual(), last_exp);
      checks++;
      if (out_valid !== 1'b0) begin
         fails++;
         $display("FAIL R2 act=%b exp=0", out_valid);
      end
      // R2: back-to-back strobes, pseudo-random addresses near the window
      lfsr = 32'h1234_5678;
      for (int k = 0; k < 200; k++) begin
         lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
         in_valid  = 1'b1;
         in_addr   = 32'h07FF_0000 + (lfsr & 32'h001F_FFFF);
         dual_mode = lfsr[24];
         q.push_back(model(in_addr, dual_mode));
         tags.push_back("R2");
         pushed++;
         @(negedge clk);
      end
      in_valid = 1'b0;
      repeat (4) @(negedge clk);
      check("R2", exp_t'(seen), exp_t'(pushed));
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule